// File: doc/BRIEF.md
# Dual synthesizer power and divider-hold sequencer

This block sets the power state of two frequency-synthesizer channels, main (index 0) and auxiliary (index 1), and decides when each channel's reference and feedback dividers are held at their load point. Each channel has a two-bit mode word made of a powerdown bit and a tri-state bit, and a strobe from its phase detector that marks the end of a charge-pump pulse. From these the block drives the prescaler, phase-detector and charge-pump enables, a charge-pump high-impedance control and a divider hold for each channel. It also drives one oscillator-buffer enable that both channels share.

Powerdown comes in two forms. The synchronous form waits for the end of the next charge-pump pulse. The asynchronous form acts on the next clock edge. When a channel wakes, its circuits are enabled at once. Its dividers stay held for a settling delay of a set number of cycles and are then released together. A separate counter-reset selector can hold the dividers of either channel or of both, whatever the power state. The mode inputs are sampled on every clock, so a channel's settings can be changed while it is powered down.

Top module: `dual_synth_pwr_seq`

## Requirements
- R1: Mode {pd,tri}=00 with the settling delay over and no counter reset selected gives pre/pfd/cp enables 1, cp_hiz 0 and div_hold 0 for that channel.
- R2: Mode 01 keeps the channel enabled and drives cp_hiz to 1.
- R3: Mode 10 (synchronous powerdown) keeps an active channel enabled until a clock edge that samples pulse_done_i=1. After that edge the channel is powered down.
- R4: Mode 11 (asynchronous powerdown) powers the channel down on the next edge, whatever pulse_done_i is.
- R5: Mode 11 arriving while a synchronous powerdown waits for its pulse powers the channel down on the next edge.
- R6: A powered-down channel has all three enables at 0, cp_hiz at 1 and div_hold at 1.
- R7: osc_en_o is 0 exactly when both channels are powered down.
- R8: When pd is cleared on a powered-down channel, its enables go to 1 on the next edge and div_hold stays 1 for exactly SETTLE_CYCLES edges, then drops.
- R9: A powerdown request during the settling delay powers the channel down on the next edge. A later wake starts a full new delay.
- R10: cnt_rst_sel_i encodes 00 none, 01 hold auxiliary dividers, 10 hold main dividers, 11 hold all dividers. A selected channel has div_hold 1 while the code is applied, and its enables are unaffected.
- R11: After reset both channels are powered down with dividers held, and osc_en_o is 0.
- R12: Clearing pd while a synchronous powerdown waits for its pulse returns the channel to normal operation without powering it down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pd_i | input | 2 | Powerdown bit per channel (0 main, 1 aux) |
| mode_tri_i | input | 2 | Tri-state bit per channel |
| pulse_done_i | input | 2 | End-of-charge-pump-pulse strobe per channel |
| cnt_rst_sel_i | input | 2 | Counter-reset selector |
| pre_en_o | output | 2 | Prescaler enable per channel |
| pfd_en_o | output | 2 | Phase-detector enable per channel |
| cp_en_o | output | 2 | Charge-pump enable per channel |
| cp_hiz_o | output | 2 | Charge-pump high-impedance control per channel |
| div_hold_o | output | 2 | Reference and feedback divider hold per channel |
| osc_en_o | output | 1 | Shared oscillator-buffer enable |

## Verification
The bench builds the block with SETTLE_CYCLES set to 5, not 64. This lets the random stimulus finish many settling windows, and cut many of them short, within a short run. With the short delay, the exact release edge, a powerdown arriving partway through the count, and a wake straight after a cut-short delay all come up often, both in the directed cases and in the random ones. The counter width for the value 5 is not a power of two, so the terminal-count compare is also covered.

// File: rtl/dsps_pkg.sv
package dsps_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    CH_ACTIVE = 2'd0,
    CH_PEND   = 2'd1,
    CH_DOWN   = 2'd2,
    CH_SETTLE = 2'd3
  } ch_state_e;

  typedef enum logic [1:0] {
    RST_NONE = 2'b00,
    RST_AUX  = 2'b01,
    RST_MAIN = 2'b10,
    RST_ALL  = 2'b11
  } cnt_rst_e;
endpackage

// File: rtl/dsps_settle_timer.sv
module dsps_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/dsps_chan_fsm.sv
module dsps_chan_fsm
  import dsps_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_i,
  input  logic      tri_i,
  input  logic      pulse_done_i,
  output ch_state_e state_d_o
);
  ch_state_e state_q, state_d;
  logic      settle_done;
  logic      settle_start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_ACTIVE: if (pd_i) state_d = tri_i ? CH_DOWN : CH_PEND;
      CH_PEND: begin
        if (!pd_i)                     state_d = CH_ACTIVE;
        else if (tri_i || pulse_done_i) state_d = CH_DOWN;
      end
      CH_DOWN:   if (!pd_i) state_d = CH_SETTLE;
      // dividers are held here, so no pulse can end a sync request: drop at once
      CH_SETTLE: begin
        if (pd_i)             state_d = CH_DOWN;
        else if (settle_done) state_d = CH_ACTIVE;
      end
      default:   state_d = CH_DOWN;
    endcase
  end

  assign settle_start = (state_q == CH_DOWN) && (state_d == CH_SETTLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CH_DOWN;
    else         state_q <= state_d;
  end

  dsps_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (settle_start),
    .run_i   (state_q == CH_SETTLE),
    .done_o  (settle_done)
  );

  assign state_d_o = state_d;
endmodule

// File: rtl/dsps_rst_decode.sv
module dsps_rst_decode
  import dsps_pkg::*;
(
  input  logic [1:0]        sel_i,
  output logic [NUM_CH-1:0] hold_o
);
  always_comb begin
    hold_o = '0;
    unique case (cnt_rst_e'(sel_i))
      RST_NONE: hold_o = '0;
      RST_AUX:  hold_o[1] = 1'b1;
      RST_MAIN: hold_o[0] = 1'b1;
      RST_ALL:  hold_o = '1;
      default:  hold_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_synth_pwr_seq.sv
module dual_synth_pwr_seq
  import dsps_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_pd_i,
  input  logic [1:0] mode_tri_i,
  input  logic [1:0] pulse_done_i,
  input  logic [1:0] cnt_rst_sel_i,
  output logic [1:0] pre_en_o,
  output logic [1:0] pfd_en_o,
  output logic [1:0] cp_en_o,
  output logic [1:0] cp_hiz_o,
  output logic [1:0] div_hold_o,
  output logic       osc_en_o
);
  ch_state_e         st_d [NUM_CH];
  logic [NUM_CH-1:0] rst_hold;
  logic [NUM_CH-1:0] up_d;

  dsps_rst_decode u_rst_dec (
    .sel_i  (cnt_rst_sel_i),
    .hold_o (rst_hold)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dsps_chan_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pd_i         (mode_pd_i[c]),
      .tri_i        (mode_tri_i[c]),
      .pulse_done_i (pulse_done_i[c]),
      .state_d_o    (st_d[c])
    );

    assign up_d[c] = (st_d[c] != CH_DOWN);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pre_en_o[c]   <= 1'b0;
        pfd_en_o[c]   <= 1'b0;
        cp_en_o[c]    <= 1'b0;
        cp_hiz_o[c]   <= 1'b1;
        div_hold_o[c] <= 1'b1;
      end else begin
        pre_en_o[c]   <= up_d[c];
        pfd_en_o[c]   <= up_d[c];
        cp_en_o[c]    <= up_d[c];
        cp_hiz_o[c]   <= !up_d[c] || (!mode_pd_i[c] && mode_tri_i[c]);
        div_hold_o[c] <= !up_d[c] || (st_d[c] == CH_SETTLE) || rst_hold[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_en_o <= 1'b0;
    else         osc_en_o <= |up_d;
  end
endmodule

// File: rtl/dsps_chk.sv
module dsps_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_pd_i,
  input logic [1:0] mode_tri_i,
  input logic [1:0] pulse_done_i,
  input logic [1:0] cnt_rst_sel_i,
  input logic [1:0] pre_en_o,
  input logic [1:0] cp_en_o,
  input logic [1:0] cp_hiz_o,
  input logic [1:0] div_hold_o,
  input logic       osc_en_o
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    AST_DOWN_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cp_en_o[c] |-> (cp_hiz_o[c] && div_hold_o[c] && !pre_en_o[c])); // R6

    AST_ASYNC_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_pd_i[c] && mode_tri_i[c]) |=> !cp_en_o[c]); // R4

    AST_SYNC_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cp_en_o[c] && !div_hold_o[c] && mode_pd_i[c] && !mode_tri_i[c] && !pulse_done_i[c])
      |=> cp_en_o[c]); // R3

    AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cp_en_o[c]) |-> div_hold_o[c]); // R8
  end

  AST_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_en_o == 2'b00) |-> !osc_en_o); // R7

  AST_OSC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_en_o != 2'b00) |-> osc_en_o); // R7

  AST_RST_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_sel_i == 2'b11) |=> (div_hold_o == 2'b11)); // R10
endmodule

bind dual_synth_pwr_seq dsps_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_pd_i     (mode_pd_i),
  .mode_tri_i    (mode_tri_i),
  .pulse_done_i  (pulse_done_i),
  .cnt_rst_sel_i (cnt_rst_sel_i),
  .pre_en_o      (pre_en_o),
  .cp_en_o       (cp_en_o),
  .cp_hiz_o      (cp_hiz_o),
  .div_hold_o    (div_hold_o),
  .osc_en_o      (osc_en_o)
);

// File: tb/sim_dual_synth_pwr_seq.sv
`timescale 1ns/1ps
module sim_dual_synth_pwr_seq;
  localparam int unsigned SC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pd = 2'b11, tri_b = 2'b00, pls = 2'b00, sel = 2'b00;
  logic [1:0] pre_en, pfd_en, cp_en, cp_hiz, div_hold;
  logic       osc_en;

  int unsigned n_vec = 0, n_bad = 0;
  bit          finished = 1'b0;

  // model state: 0 active, 1 pending sync, 2 down, 3 settling
  int ms [2];
  int mc [2];

  always #5 clk = ~clk;

  dual_synth_pwr_seq #(.SETTLE_CYCLES(SC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_pd_i(pd), .mode_tri_i(tri_b),
    .pulse_done_i(pls), .cnt_rst_sel_i(sel), .pre_en_o(pre_en), .pfd_en_o(pfd_en),
    .cp_en_o(cp_en), .cp_hiz_o(cp_hiz), .div_hold_o(div_hold), .osc_en_o(osc_en)
  );

  function automatic logic [10:0] expect_vec(logic [1:0] p, logic [1:0] t, logic [1:0] s);
    logic [1:0] en, hz, hd, rm;
    rm = {s[0], s[1]};
    for (int c = 0; c < 2; c++) begin
      en[c] = (ms[c] != 2);
      hz[c] = (ms[c] == 2) || (!p[c] && t[c]);
      hd[c] = (ms[c] == 2) || (ms[c] == 3) || rm[c];
    end
    return {|en, hd, hz, en, en, en};
  endfunction

  task automatic model_step(logic [1:0] p, logic [1:0] t, logic [1:0] q);
    for (int c = 0; c < 2; c++) begin
      case (ms[c])
        0: if (p[c]) ms[c] = t[c] ? 2 : 1;
        1: if (!p[c]) ms[c] = 0; else if (t[c] || q[c]) ms[c] = 2;
        2: if (!p[c]) begin ms[c] = 3; mc[c] = 0; end
        default: begin
          if (p[c]) ms[c] = 2;
          else if (mc[c] == SC - 1) ms[c] = 0;
          else mc[c]++;
        end
      endcase
    end
  endtask

  task automatic compare(string tag, logic [10:0] exp_v);
    logic [10:0] act;
    act = {osc_en, div_hold, cp_hiz, cp_en, pfd_en, pre_en};
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic tick(string tag);
    logic [1:0] p, t, q, s;
    p = pd; t = tri_b; q = pls; s = sel;
    @(posedge clk);
    #1;
    model_step(p, t, q);
    compare(tag, expect_vec(p, t, s));
  endtask

  task automatic drive(logic [1:0] p, logic [1:0] t, logic [1:0] q, logic [1:0] s);
    pd = p; tri_b = t; pls = q; sel = s;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ms[0] = 2; ms[1] = 2; mc[0] = 0; mc[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R11 reset", expect_vec(pd, tri_b, sel));
    compare("R11 reset literal", 11'b0_11_11_00_00_00);
    rst_n = 1'b1;
    tick("R6 stays down");

    // wake main, aux stays in sync powerdown
    drive(2'b10, 2'b00, 2'b00, 2'b00);
    tick("R8 wake edge");
    compare("R8 enabled and held", 11'b1_11_10_01_01_01);
    for (int i = 1; i < SC; i++) tick("R8 still held");
    tick("R1 released");
    compare("R1 normal literal", 11'b1_10_10_01_01_01);
    compare("R7 one channel up", {1'b1, 10'b10_10_01_01_01});

    drive(2'b10, 2'b01, 2'b00, 2'b00);
    tick("R2 hiz");

    drive(2'b11, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i < 3; i++) tick("R3 waiting");
    drive(2'b11, 2'b00, 2'b01, 2'b00);
    tick("R3 pulse seen");
    compare("R7 both down", 11'b0_11_11_00_00_00);

    drive(2'b10, 2'b00, 2'b00, 2'b00);
    tick("R9 wake");
    tick("R9 settling");
    drive(2'b11, 2'b00, 2'b00, 2'b00);
    tick("R9 down in settle");
    drive(2'b10, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i < SC; i++) tick("R9 full restart");
    tick("R9 released");

    drive(2'b11, 2'b00, 2'b00, 2'b00);
    tick("R5 pending");
    drive(2'b11, 2'b01, 2'b00, 2'b00);
    tick("R5 async overrides");

    drive(2'b10, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i <= SC; i++) tick("R8 wake again");
    drive(2'b11, 2'b01, 2'b00, 2'b00);
    tick("R4 async");

    drive(2'b10, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i <= SC; i++) tick("R8 wake");
    drive(2'b11, 2'b00, 2'b00, 2'b00);
    tick("R12 pending");
    drive(2'b10, 2'b00, 2'b00, 2'b00);
    tick("R12 cancelled");
    tick("R12 stays up");

    drive(2'b00, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i <= SC; i++) tick("R1 both up");
    drive(2'b00, 2'b00, 2'b00, 2'b01);
    tick("R10 aux hold");
    drive(2'b00, 2'b00, 2'b00, 2'b10);
    tick("R10 main hold");
    drive(2'b00, 2'b00, 2'b00, 2'b11);
    tick("R10 all hold");
    compare("R10 all literal", 11'b1_11_00_11_11_11);
    drive(2'b00, 2'b00, 2'b00, 2'b00);
    tick("R10 cleared");

    begin
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      for (int i = 0; i < 4000; i++) begin
        logic [1:0] np, nt;
        np = pd; nt = tri_b;
        for (int c = 0; c < 2; c++) begin
          if ($urandom_range(7) == 0) np[c] = ~np[c];
          if ($urandom_range(5) == 0) nt[c] = ~nt[c];
        end
        drive(np, nt, 2'($urandom_range(3)) & {$urandom_range(3) == 0, $urandom_range(3) == 0},
              ($urandom_range(9) == 0) ? 2'($urandom_range(3)) : 2'b00);
        tick("RND mixed R3 R4 R8 R9");
      end
    end
    finish_run();
  end
endmodule